// File: doc/BRIEF.md
# Grouped Level-Sensitive Interrupt Combiner

This block gathers a wide bank of level-sensitive interrupt lines into a smaller set of group requests. Input lines are taken eight at a time, and each set of eight is one group. Each group keeps an 8-bit raw pending vector, which follows its inputs, and an 8-bit enable mask. The group request output is high whenever an enabled source of the group is pending. A downstream interrupt controller sees one request per group. Software reads the status registers to find which source inside the group fired.

A 32-bit word-addressed register port sets and clears mask bits and reads status. Registers come in 16-byte quads, and each quad serves four consecutive groups. Group 4q+i uses byte lane i of every word in quad q. Two summary words after the last quad hold one bit per group, set when that group has a masked pending source. A build-time option marks the instance as an external combiner that serves fewer groups. In that option, inputs of the groups above the limit are never recorded.

Top module: `irq_group_combiner`

## Requirements
- R1: Input line n is recorded as pending bit (n mod 8) of group n/8. Reading quad offset 0x8 (raw status) returns the pending bytes of groups 4q..4q+3, with group 4q+i in bits [8i+7:8i].
- R2: Pending bits are level-sensitive and are not latched. A pending bit follows its input line one clock later, and it falls when the line falls.
- R3: Group output `grp_irq[g]` is high exactly when mask AND pending of group g is non-zero. It updates one clock after an input change or a mask write.
- R4: A write to quad offset 0x0 (enable-set) ORs each byte lane into the mask of the corresponding group. Mask bits not written as 1 keep their value.
- R5: A write to quad offset 0x4 (enable-clear) clears each mask bit written as 1. All other mask bits keep their value.
- R6: Reading quad offset 0xC (masked status) returns mask AND pending for the four groups of the quad, in the same lanes as R1.
- R7: Reads at 0x100 return the masked-pending summary of groups 0..31, with group g in bit g. Reads at 0x104 return the summary of groups 32..63, with group g in bit g-32.
- R8: Reads at quad offsets 0x0 and 0x4 return the last word written to that address.
- R9: Reset clears every mask bit, every pending bit and every output. After reset, the stored words at 0xC0, 0xC4, 0xD0 and 0xD4 read 0x01010101 and all other stored words read 0.
- R10: A write to a status offset (0x8, 0xC), to a summary word or to any address outside the quads changes no state. Such a write raises `bus_err` for one clock, in the clock after the write. A valid write leaves `bus_err` low.
- R11: With `EXT_MODE` set, inputs of groups numbered `EXT_GROUPS` and above are ignored. Their pending bits stay 0 and their outputs stay low even when enabled.
- R12: Reads at addresses with no register (0x108 and above) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 512 | Level-sensitive interrupt lines, line n in group n/8 |
| bus_addr | input | 10 | Byte address of the register access (bits [1:0] ignored) |
| bus_wr | input | 1 | Write strobe, one write per clock it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational from registered state |
| grp_irq | output | 64 | Registered per-group request |
| bus_err | output | 1 | One-clock pulse after a rejected write |

## Verification
The hardest case is a source whose line stays high while its mask bit is cleared. The group output must then fall, and the raw status must still show the source. The stimulus reaches this case by holding line 3 high, enabling it, and clearing only that mask bit. It then checks the output, the masked status and the raw status separately. A second instance built in external mode receives the same stimulus, so a group above its limit can be enabled and driven while its pending bit is expected to stay 0. Rejected writes are aimed at status and summary words that already hold known non-zero values, so a write that leaks into state shows up in the readback.

// File: rtl/irq_group_combiner_pkg.sv
package irq_group_combiner_pkg;

    // Sources per group; fixed by the byte-lane layout of the register quads.
    localparam int LANE_W = 8;

    // Register selected by address bits [3:2] inside a quad.
    typedef enum logic [1:0] {
        SEL_SET    = 2'd0,
        SEL_CLR    = 2'd1,
        SEL_RAW    = 2'd2,
        SEL_MASKED = 2'd3
    } quad_sel_e;

    // Per-group state.
    typedef struct packed {
        logic [LANE_W-1:0] mask;
        logic [LANE_W-1:0] pend;
        logic              req;
    } grp_state_t;

    // Stored words that do not reset to zero.
    localparam logic [31:0] STORED_RST_WORD = 32'h0101_0101;
    localparam int          STORED_RST_QA   = 12;
    localparam int          STORED_RST_QB   = 13;

endpackage

// File: rtl/irq_group_cell.sv
module irq_group_cell
    import irq_group_combiner_pkg::*;
#(
    parameter bit ACCEPT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] src_in,
    input  logic [LANE_W-1:0] set_bits,
    input  logic [LANE_W-1:0] clr_bits,
    output logic [LANE_W-1:0] mask_o,
    output logic [LANE_W-1:0] pend_o,
    output logic              req_o
);

    grp_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = ACCEPT ? src_in : '0;
        st_d.mask = (st_q.mask | set_bits) & ~clr_bits;
        st_d.req  = |(st_d.mask & st_d.pend);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;
    assign pend_o = st_q.pend;
    assign req_o  = st_q.req;

    // R4: bits written by enable-set are set one clock later
    a_r4_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bits != '0) |=> ((mask_o & $past(set_bits)) == $past(set_bits)));

    // R5: bits written by enable-clear are cleared one clock later
    a_r5_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits != '0) |=> ((mask_o & $past(clr_bits)) == '0));

    generate
        if (ACCEPT) begin : g_live
            // R2: pending follows the input lines one clock later
            a_r2_pend_follows: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (pend_o == $past(src_in)));
        end else begin : g_dead
            // R11: a group outside the accepted range never requests
            a_r11_ignored: assert property (@(posedge clk) disable iff (!rst_n)
                (src_in != '0) |=> (!req_o && pend_o == '0));
        end
    endgenerate

endmodule

// File: rtl/irq_group_regfile.sv
module irq_group_regfile
    import irq_group_combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter int ADDR_W     = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [31:0]                  bus_wdata,
    input  logic [NUM_GROUPS*LANE_W-1:0] mask_flat,
    input  logic [NUM_GROUPS*LANE_W-1:0] pend_flat,
    input  logic [NUM_GROUPS-1:0]        grp_req,
    output logic [NUM_GROUPS*LANE_W-1:0] set_flat,
    output logic [NUM_GROUPS*LANE_W-1:0] clr_flat,
    output logic [31:0]                  bus_rdata,
    output logic                         bus_err
);

    localparam int QUADS     = NUM_GROUPS / 4;
    localparam int QW        = (QUADS > 1) ? $clog2(QUADS) : 1;
    localparam int QF_W      = ADDR_W - 4;
    localparam int SUM_WORDS = (NUM_GROUPS + 31) / 32;

    typedef struct packed {
        logic [QUADS-1:0][1:0][31:0] words;
        logic                        err;
    } rf_state_t;

    rf_state_t rf_d, rf_q;

    logic [QF_W-1:0]           quad_f;
    logic [QW-1:0]             quad_i;
    quad_sel_e                 sel;
    logic                      in_grp;
    logic                      in_sum;
    logic                      wr_ok;
    logic [SUM_WORDS*32-1:0]   sum_pad;
    logic [NUM_GROUPS*LANE_W-1:0] masked_flat;

    assign quad_f      = bus_addr[ADDR_W-1:4];
    assign quad_i      = quad_f[QW-1:0];
    assign sel         = quad_sel_e'(bus_addr[3:2]);
    assign in_grp      = (quad_f < QF_W'(QUADS));
    assign in_sum      = (quad_f == QF_W'(QUADS)) && (int'(bus_addr[3:2]) < SUM_WORDS);
    assign wr_ok       = in_grp && (sel == SEL_SET || sel == SEL_CLR);
    assign masked_flat = mask_flat & pend_flat;

    always_comb begin
        sum_pad                 = '0;
        sum_pad[NUM_GROUPS-1:0] = grp_req;
    end

    // Write decode and next state.
    always_comb begin
        rf_d     = rf_q;
        rf_d.err = 1'b0;
        set_flat = '0;
        clr_flat = '0;
        if (bus_wr) begin
            if (wr_ok && sel == SEL_SET) begin
                rf_d.words[quad_i][0]     = bus_wdata;
                set_flat[quad_i*32 +: 32] = bus_wdata;
            end else if (wr_ok) begin
                rf_d.words[quad_i][1]     = bus_wdata;
                clr_flat[quad_i*32 +: 32] = bus_wdata;
            end else begin
                rf_d.err = 1'b1;
            end
        end
    end

    // Read mux.
    always_comb begin
        bus_rdata = '0;
        if (in_grp) begin
            unique case (sel)
                SEL_SET:    bus_rdata = rf_q.words[quad_i][0];
                SEL_CLR:    bus_rdata = rf_q.words[quad_i][1];
                SEL_RAW:    bus_rdata = pend_flat[quad_i*32 +: 32];
                SEL_MASKED: bus_rdata = masked_flat[quad_i*32 +: 32];
                default:    bus_rdata = '0;
            endcase
        end else if (in_sum) begin
            bus_rdata = sum_pad[bus_addr[3:2]*32 +: 32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int q = 0; q < QUADS; q++) begin
                for (int w = 0; w < 2; w++) begin
                    rf_q.words[q][w] <= (q == STORED_RST_QA || q == STORED_RST_QB)
                                        ? STORED_RST_WORD : 32'h0;
                end
            end
            rf_q.err <= 1'b0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign bus_err = rf_q.err;

    // R10: a rejected write raises the error pulse in the next clock
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_ok) |=> bus_err);

    // R10: a rejected write drives no set or clear lanes
    a_r10_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !wr_ok) |-> (set_flat == '0 && clr_flat == '0));

    // R10: an accepted write leaves the error output low
    a_r10_ok_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && wr_ok) |=> !bus_err);

endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import irq_group_combiner_pkg::*;
#(
    parameter int NUM_GROUPS = 64,
    parameter int ADDR_W     = 10,
    parameter bit EXT_MODE   = 1'b0,
    parameter int EXT_GROUPS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*LANE_W-1:0] irq_src,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_wr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic [NUM_GROUPS-1:0]        grp_irq,
    output logic                         bus_err
);

    localparam int LINES = NUM_GROUPS * LANE_W;

    logic [LINES-1:0] mask_flat;
    logic [LINES-1:0] pend_flat;
    logic [LINES-1:0] set_flat;
    logic [LINES-1:0] clr_flat;

    irq_group_regfile #(
        .NUM_GROUPS (NUM_GROUPS),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .mask_flat (mask_flat),
        .pend_flat (pend_flat),
        .grp_req   (grp_irq),
        .set_flat  (set_flat),
        .clr_flat  (clr_flat),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err)
    );

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            localparam bit LIVE = !(EXT_MODE && (g >= EXT_GROUPS));
            irq_group_cell #(
                .ACCEPT (LIVE)
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_in   (irq_src[g*LANE_W +: LANE_W]),
                .set_bits (set_flat[g*LANE_W +: LANE_W]),
                .clr_bits (clr_flat[g*LANE_W +: LANE_W]),
                .mask_o   (mask_flat[g*LANE_W +: LANE_W]),
                .pend_o   (pend_flat[g*LANE_W +: LANE_W]),
                .req_o    (grp_irq[g])
            );
        end
    endgenerate

    // R3: a request needs at least one pending source somewhere
    a_r3_req_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_irq != '0) |-> (pend_flat != '0));

endmodule

// File: tb/irq_group_combiner_test.sv
`timescale 1ns/1ps
module irq_group_combiner_test;

    localparam int NG = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [511:0]  irq_src = '0;
    logic [9:0]    addr = '0;
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata, rdata_x;
    logic [NG-1:0] gi, gi_x;
    logic          err, err_x;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_group_combiner uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata),
        .grp_irq(gi), .bus_err(err)
    );

    irq_group_combiner #(.EXT_MODE(1'b1), .EXT_GROUPS(16)) uut_ext (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(addr),
        .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata_x),
        .grp_irq(gi_x), .bus_err(err_x)
    );

    // op: 0 line high, 1 line low, 2 write, 3 read-compare, 4 group output compare
    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  req;
        logic [9:0]  arg;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{3'd2, 4'd4,  10'h000, 32'h0000_00FF, 32'h0},           // R4 enable group 0
        '{3'd3, 4'd8,  10'h000, 32'h0,         32'h0000_00FF},   // R8
        '{3'd0, 4'd2,  10'd3,   32'h0,         32'h0},
        '{3'd4, 4'd3,  10'd0,   32'h0,         32'h1},           // R3
        '{3'd3, 4'd1,  10'h008, 32'h0,         32'h0000_0008},   // R1
        '{3'd3, 4'd6,  10'h00C, 32'h0,         32'h0000_0008},   // R6
        '{3'd3, 4'd7,  10'h100, 32'h0,         32'h0000_0001},   // R7
        '{3'd0, 4'd1,  10'd21,  32'h0,         32'h0},
        '{3'd3, 4'd1,  10'h008, 32'h0,         32'h0020_0008},   // R1 lane 2
        '{3'd3, 4'd6,  10'h00C, 32'h0,         32'h0000_0008},   // R6
        '{3'd4, 4'd3,  10'd2,   32'h0,         32'h0},           // R3 masked off
        '{3'd2, 4'd4,  10'h000, 32'h0020_0000, 32'h0},           // R4
        '{3'd4, 4'd3,  10'd2,   32'h0,         32'h1},           // R3
        '{3'd4, 4'd4,  10'd0,   32'h0,         32'h1},           // R4 group 0 kept
        '{3'd3, 4'd7,  10'h100, 32'h0,         32'h0000_0005},   // R7
        '{3'd2, 4'd5,  10'h004, 32'h0000_0008, 32'h0},           // R5
        '{3'd4, 4'd5,  10'd0,   32'h0,         32'h0},           // R5 line still high
        '{3'd3, 4'd1,  10'h008, 32'h0,         32'h0020_0008},   // R1 raw unchanged
        '{3'd3, 4'd6,  10'h00C, 32'h0,         32'h0020_0000},   // R6
        '{3'd3, 4'd8,  10'h004, 32'h0,         32'h0000_0008},   // R8
        '{3'd1, 4'd2,  10'd3,   32'h0,         32'h0},
        '{3'd0, 4'd2,  10'd500, 32'h0,         32'h0},
        '{3'd2, 4'd4,  10'h0F0, 32'h0010_0000, 32'h0},
        '{3'd4, 4'd3,  10'd62,  32'h0,         32'h1},           // R3 top quad
        '{3'd3, 4'd7,  10'h104, 32'h0,         32'h4000_0000},   // R7 upper word
        '{3'd1, 4'd2,  10'd500, 32'h0,         32'h0},
        '{3'd4, 4'd2,  10'd62,  32'h0,         32'h0}            // R2 no latching
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        e  = err;
    endtask

    task automatic do_line(input int n, input logic v);
        @(negedge clk);
        irq_src[n] = v;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [9:0] a, output logic [31:0] r);
        addr = a;
        #1;
        r = rdata;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic        e;
        repeat (3) @(negedge clk);

        // R9 during reset
        check("R9 outputs in reset", {31'h0, |gi}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(10'h0C0, r); check("R9 word 0xC0", r, 32'h0101_0101);
        do_read(10'h0C4, r); check("R9 word 0xC4", r, 32'h0101_0101);
        do_read(10'h0D0, r); check("R9 word 0xD0", r, 32'h0101_0101);
        do_read(10'h0D4, r); check("R9 word 0xD4", r, 32'h0101_0101);
        do_read(10'h0C8, r); check("R9 raw status", r, 32'h0);
        do_read(10'h000, r); check("R9 word 0x00", r, 32'h0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", TBL[i].req, i);
            case (TBL[i].op)
                3'd0: do_line(int'(TBL[i].arg), 1'b1);
                3'd1: do_line(int'(TBL[i].arg), 1'b0);
                3'd2: begin
                    do_write(TBL[i].arg, TBL[i].data, e);
                    check({tag, " err"}, {31'h0, e}, 32'h0);
                end
                3'd3: begin
                    do_read(TBL[i].arg, r);
                    check(tag, r, TBL[i].exp);
                end
                default: check(tag, {31'h0, gi[TBL[i].arg[5:0]]}, TBL[i].exp);
            endcase
        end

        // R10: rejected writes leave state untouched and pulse the error output
        do_write(10'h008, 32'hFFFF_FFFF, e);
        check("R10 err raw write", {31'h0, e}, 32'h1);
        do_read(10'h008, r); check("R10 raw kept", r, 32'h0020_0000);
        do_write(10'h100, 32'hFFFF_FFFF, e);
        check("R10 err summary write", {31'h0, e}, 32'h1);
        do_read(10'h100, r); check("R10 summary kept", r, 32'h0000_0004);
        do_write(10'h00C, 32'hFFFF_FFFF, e);
        check("R10 err masked write", {31'h0, e}, 32'h1);
        do_read(10'h00C, r); check("R10 masked kept", r, 32'h0020_0000);
        @(negedge clk);
        check("R10 pulse one clock", {31'h0, err}, 32'h0);

        // R12: unmapped reads are zero
        do_read(10'h108, r); check("R12 read 0x108", r, 32'h0);
        do_read(10'h3FC, r); check("R12 read 0x3FC", r, 32'h0);

        // R11: group 20 is above the external limit, group 3 is below it
        do_write(10'h050, 32'h0000_0001, e);
        do_write(10'h000, 32'h0100_0000, e);
        do_line(160, 1'b1);
        do_line(24, 1'b1);
        check("R11 normal group 20 out", {31'h0, gi[20]}, 32'h1);
        check("R11 ext group 20 out", {31'h0, gi_x[20]}, 32'h0);
        addr = 10'h058;
        #1;
        check("R11 ext group 20 raw", rdata_x, 32'h0);
        check("R11 normal group 20 raw", rdata, 32'h0000_0001);
        check("R11 ext group 3 out", {31'h0, gi_x[3]}, 32'h1);

        // R9: reset again after activity
        @(negedge clk);
        irq_src = '0;
        rst_n   = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 outputs after reset", {31'h0, |gi}, 32'h0);
        do_read(10'h000, r); check("R9 set word cleared", r, 32'h0);
        do_read(10'h0C4, r); check("R9 word 0xC4 again", r, 32'h0101_0101);
        do_line(3, 1'b1);
        check("R9 mask cleared", {31'h0, gi[0]}, 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule